// File: doc/BRIEF.md
# Variable-length bit field extractor

This block pulls a field of 0 to 32 bits out of a 64-bit value formed by a pair of 32-bit words, the low word supplying bits 31:0 and the high word bits 63:32. The field is returned right-justified in a 32-bit result, either sign-extended or zero-extended. A field may begin near the top of the low word and run on into the high word.

Register mode takes the start position directly as a bit index from 0 to 31 into the low word. Memory mode treats the 32-bit position as a signed byte offset in bits 31:3 and a bit index in bits 2:0. The block adds the offset to a base byte address and reports the starting byte address, the bit index within that byte, and how many bytes the field covers. The caller then presents the bytes from the starting byte onward, lowest byte in bits 7:0 of the low word, and the field is taken from the bit index. A sequencer pulses the start strobe once per operation, and the results come back registered one clock later. The block does no memory fetches of its own.

Top module: `bitfield_extract`

## Requirements
- R1: A size of 0 gives a result of exactly zero, in both modes and both extension modes, and does not raise the reserved flag.
- R2: In register mode with position p (0 to 31) and size s (0 to 32), result bit i for i < s equals bit p+i of {hi_word_i, lo_word_i}, so bits beyond 31 are taken from the high word.
- R3: In signed mode with s > 0, every result bit at index s or above equals field bit s-1.
- R4: In unsigned mode, every result bit at index s or above is zero.
- R5: In memory mode, byte_addr_o equals base_addr_i plus pos_i[31:3] sign-extended to 32 bits (modulo 2^32), bit_ofs_o equals pos_i[2:0], and the field is read from {hi_word_i, lo_word_i} starting at bit pos_i[2:0].
- R6: In memory mode, byte_cnt_o equals ceil((pos_i[2:0] + s) / 8), with a minimum of 1, so it lies between 1 and 5. In register mode, byte_addr_o, bit_ofs_o and byte_cnt_o are zero.
- R7: A size above 32 in either mode, or a position above 31 in register mode, sets rsvd_o and forces result_o, byte_addr_o, bit_ofs_o and byte_cnt_o to zero. Otherwise rsvd_o is clear.
- R8: An operation sampled with start_i at a rising clock edge shows its outputs after that edge, with done_o high for exactly that one cycle. done_o is low after any edge at which start_i was low.
- R9: Reset clears every output to zero. Between operations, all outputs except done_o keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation strobe, sampled at the rising edge |
| mem_mode_i | input | 1 | 1 selects memory mode, 0 selects register mode |
| signed_i | input | 1 | 1 sign-extends the field, 0 zero-extends it |
| lo_word_i | input | 32 | Source bits 31:0 |
| hi_word_i | input | 32 | Source bits 63:32 |
| pos_i | input | 32 | Start position |
| size_i | input | 6 | Field size in bits |
| base_addr_i | input | 32 | Base byte address for memory mode |
| result_o | output | 32 | Extended field |
| byte_addr_o | output | 32 | Byte address where the field starts (memory mode) |
| bit_ofs_o | output | 3 | Bit index within the starting byte (memory mode) |
| byte_cnt_o | output | 3 | Bytes covered by the field (memory mode) |
| rsvd_o | output | 1 | Reserved operand |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The register-mode extraction is swept over every position from 0 to 31 and every size from 0 to 32, in both extension modes, with random source words. This separates errors in the shift, the mask edge and the sign bit index, and it covers the fields that run on into the high word. Memory mode uses random positions, including negative ones, and random bases, which shows whether the offset is sign-extended and whether the byte count rounds correctly at a byte boundary. Directed sizes of 33 and 63, positions of 32 and all ones, and a field of all ones and of a single set top bit show that the reserved check and the two extension modes behave as required.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int BIT_IDX_W = 3;  // bit index within a byte

  typedef enum logic {
    MODE_REG = 1'b0,
    MODE_MEM = 1'b1
  } bfx_mode_e;
endpackage

// File: rtl/bfx_field_slice.sv
module bfx_field_slice #(
  parameter  int DATA_W  = 32,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int SIZE_W  = SHIFT_W + 1
) (
  input  logic [DATA_W-1:0]  lo_i,
  input  logic [DATA_W-1:0]  hi_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic               signed_i,
  output logic [DATA_W-1:0]  field_o
);
  logic [2*DATA_W-1:0] pair;
  logic [DATA_W-1:0]   raw;
  logic [DATA_W-1:0]   mask;
  logic [SHIFT_W-1:0]  msb_idx;
  logic                sign;

  assign pair = {hi_i, lo_i};
  assign raw  = DATA_W'(pair >> shift_i);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (SIZE_W'(i) < size_i);
  end

  assign msb_idx = SHIFT_W'(size_i - SIZE_W'(1));
  assign sign    = signed_i && (size_i != '0) && raw[msb_idx];
  assign field_o = (raw & mask) | ({DATA_W{sign}} & ~mask);
endmodule

// File: rtl/bfx_locate.sv
module bfx_locate
  import bfx_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int SIZE_W = 6,
  parameter  int CNT_W  = 3,
  localparam int SUM_W  = SIZE_W + 2
) (
  input  logic [ADDR_W-1:0]    pos_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  bfx_mode_e            mode_i,
  output logic [ADDR_W-1:0]    byte_addr_o,
  output logic [BIT_IDX_W-1:0] bit_ofs_o,
  output logic [CNT_W-1:0]     byte_cnt_o
);
  logic [ADDR_W-1:0] ofs_ext;
  logic [SUM_W-1:0]  span;
  logic [SUM_W-1:0]  bytes;

  assign ofs_ext = {{BIT_IDX_W{pos_i[ADDR_W-1]}}, pos_i[ADDR_W-1:BIT_IDX_W]};
  // round up to whole bytes
  assign span  = SUM_W'(pos_i[BIT_IDX_W-1:0]) + SUM_W'(size_i) + SUM_W'(7);
  assign bytes = span >> BIT_IDX_W;

  always_comb begin
    byte_addr_o = '0;
    bit_ofs_o   = '0;
    byte_cnt_o  = '0;
    if (mode_i == MODE_MEM) begin
      byte_addr_o = base_i + ofs_ext;
      bit_ofs_o   = pos_i[BIT_IDX_W-1:0];
      byte_cnt_o  = (bytes == '0) ? CNT_W'(1) : CNT_W'(bytes);
    end
  end
endmodule

// File: rtl/bfx_rsvd_check.sv
module bfx_rsvd_check
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 6
) (
  input  logic [ADDR_W-1:0] pos_i,
  input  logic [SIZE_W-1:0] size_i,
  input  bfx_mode_e         mode_i,
  output logic              rsvd_o
);
  logic size_bad, pos_bad;

  assign size_bad = size_i > SIZE_W'(DATA_W);
  assign pos_bad  = (mode_i == MODE_REG) && (pos_i >= ADDR_W'(DATA_W));
  assign rsvd_o   = size_bad || pos_bad;
endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract
  import bfx_pkg::*;
#(
  parameter  int DATA_W  = 32,
  parameter  int ADDR_W  = 32,
  localparam int SHIFT_W = $clog2(DATA_W),
  localparam int SIZE_W  = SHIFT_W + 1,
  localparam int CNT_W   = $clog2((DATA_W + 14) / 8 + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 mem_mode_i,
  input  logic                 signed_i,
  input  logic [DATA_W-1:0]    lo_word_i,
  input  logic [DATA_W-1:0]    hi_word_i,
  input  logic [ADDR_W-1:0]    pos_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic [ADDR_W-1:0]    base_addr_i,
  output logic [DATA_W-1:0]    result_o,
  output logic [ADDR_W-1:0]    byte_addr_o,
  output logic [BIT_IDX_W-1:0] bit_ofs_o,
  output logic [CNT_W-1:0]     byte_cnt_o,
  output logic                 rsvd_o,
  output logic                 done_o
);
  bfx_mode_e            mode;
  logic [SHIFT_W-1:0]   shift;
  logic [DATA_W-1:0]    field;
  logic [ADDR_W-1:0]    loc_addr;
  logic [BIT_IDX_W-1:0] loc_ofs;
  logic [CNT_W-1:0]     loc_cnt;
  logic                 rsvd;

  assign mode  = bfx_mode_e'(mem_mode_i);
  // memory mode starts inside the first byte only
  assign shift = (mode == MODE_MEM) ? SHIFT_W'(pos_i[BIT_IDX_W-1:0])
                                    : pos_i[SHIFT_W-1:0];

  bfx_field_slice #(.DATA_W(DATA_W)) i_slice (
    .lo_i     (lo_word_i),
    .hi_i     (hi_word_i),
    .shift_i  (shift),
    .size_i   (size_i),
    .signed_i (signed_i),
    .field_o  (field)
  );

  bfx_locate #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) i_locate (
    .pos_i       (pos_i),
    .base_i      (base_addr_i),
    .size_i      (size_i),
    .mode_i      (mode),
    .byte_addr_o (loc_addr),
    .bit_ofs_o   (loc_ofs),
    .byte_cnt_o  (loc_cnt)
  );

  bfx_rsvd_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_rsvd (
    .pos_i  (pos_i),
    .size_i (size_i),
    .mode_i (mode),
    .rsvd_o (rsvd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      byte_addr_o <= '0;
      bit_ofs_o   <= '0;
      byte_cnt_o  <= '0;
      rsvd_o      <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        rsvd_o      <= rsvd;
        result_o    <= rsvd ? '0 : field;
        byte_addr_o <= rsvd ? '0 : loc_addr;
        bit_ofs_o   <= rsvd ? '0 : loc_ofs;
        byte_cnt_o  <= rsvd ? '0 : loc_cnt;
      end
    end
  end

  p_size_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && size_i == '0 |=> result_o == '0 && !rsvd_o);

  p_sign_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && signed_i && size_i != '0 && size_i <= SIZE_W'(DATA_W)
    |=> result_o[DATA_W-1] == result_o[$past(size_i) - SIZE_W'(1)]);

  p_zero_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !signed_i |=> (result_o >> $past(size_i)) == '0);

  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mem_mode_i && size_i <= SIZE_W'(DATA_W)
    |=> byte_cnt_o >= CNT_W'(1) && byte_cnt_o <= CNT_W'(5));

  p_rsvd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> result_o == '0 && byte_cnt_o == '0 && byte_addr_o == '0);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o) && $stable(byte_addr_o) && $stable(rsvd_o));
endmodule

// File: tb/test_bitfield_extract.sv
module test_bitfield_extract;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mem_mode_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] lo_word_i = '0;
  logic [31:0] hi_word_i = '0;
  logic [31:0] pos_i = '0;
  logic [5:0]  size_i = '0;
  logic [31:0] base_addr_i = '0;
  logic [31:0] result_o;
  logic [31:0] byte_addr_o;
  logic [2:0]  bit_ofs_o;
  logic [2:0]  byte_cnt_o;
  logic        rsvd_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  bitfield_extract i_bitfield_extract (
    .clk_i, .rst_ni, .start_i, .mem_mode_i, .signed_i, .lo_word_i, .hi_word_i,
    .pos_i, .size_i, .base_addr_i, .result_o, .byte_addr_o, .bit_ofs_o,
    .byte_cnt_o, .rsvd_o, .done_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_field(logic [31:0] lo, logic [31:0] hi,
                                            int start, int size, bit sgn);
    logic [63:0] pair = {hi, lo};
    logic [31:0] r = '0;
    for (int i = 0; i < size; i++) r[i] = pair[start + i];
    if (sgn && size > 0)
      for (int i = size; i < 32; i++) r[i] = pair[start + size - 1];
    return r;
  endfunction

  task automatic run_op(bit mem, bit sgn, logic [31:0] lo, logic [31:0] hi,
                        logic [31:0] pos, int size, logic [31:0] base);
    bit          rsv;
    int          start;
    int          cnt;
    logic [31:0] e_res, e_addr, e_ofs, e_cnt;
    @(negedge clk_i);
    mem_mode_i = mem; signed_i = sgn; lo_word_i = lo; hi_word_i = hi;
    pos_i = pos; size_i = 6'(size); base_addr_i = base; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    rsv = (size > 32) || (!mem && pos > 31);
    start = mem ? int'(pos[2:0]) : int'(pos[4:0]);
    e_res = '0; e_addr = '0; e_ofs = '0; e_cnt = '0;
    if (!rsv) begin
      e_res = ref_field(lo, hi, start, size, sgn);
      if (mem) begin
        e_addr = base + 32'($signed(pos) >>> 3);
        e_ofs  = 32'(pos[2:0]);
        cnt    = (int'(pos[2:0]) + size + 7) / 8;
        e_cnt  = (cnt == 0) ? 32'd1 : 32'(cnt);
      end
    end
    // R2 R3 R4 R5: field value
    chk(mem ? "R5 result" : (sgn ? "R3 result" : "R4 result"), result_o, e_res);
    chk("R7 rsvd", 32'(rsvd_o), 32'(rsv));
    chk("R8 done", 32'(done_o), 32'd1);
    if (mem || rsv) begin
      chk("R5 byte_addr", byte_addr_o, e_addr);
      chk("R5 bit_ofs", 32'(bit_ofs_o), e_ofs);
      chk("R6 byte_cnt", 32'(byte_cnt_o), e_cnt);
    end else begin
      chk("R6 reg mode addr", byte_addr_o | 32'(bit_ofs_o) | 32'(byte_cnt_o), 32'd0);
    end
  endtask

  task automatic hold_check();
    logic [31:0] r = result_o;
    logic [31:0] a = byte_addr_o;
    lo_word_i = ~lo_word_i; pos_i = pos_i + 1; size_i = size_i ^ 6'd5;
    @(negedge clk_i);
    chk("R8 done low", 32'(done_o), 32'd0);
    chk("R9 hold result", result_o, r);
    chk("R9 hold addr", byte_addr_o, a);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R9 reset result", result_o, 32'd0);
    chk("R9 reset flags", 32'({rsvd_o, done_o, bit_ofs_o, byte_cnt_o}), 32'd0);
    rst_ni = 1'b1;

    // R1 size zero, all modes
    run_op(0, 1, 32'hffff_ffff, 32'hffff_ffff, 32'd7, 0, 32'd0);
    run_op(1, 1, 32'hffff_ffff, 32'hffff_ffff, 32'd5, 0, 32'h100);
    chk("R1 zero field", result_o, 32'd0);

    // R2 R3 R4 exhaustive register-mode sweep
    for (int p = 0; p < 32; p++)
      for (int s = 0; s <= 32; s++)
        for (int g = 0; g < 2; g++)
          run_op(0, g[0], $urandom, $urandom, 32'(p), s, $urandom);
    hold_check();

    // R3 R4 directed: single set top bit spanning into high word
    run_op(0, 1, 32'h8000_0000, 32'h0, 32'd31, 1, 32'd0);
    chk("R3 single sign bit", result_o, 32'hffff_ffff);
    run_op(0, 0, 32'h8000_0000, 32'h0, 32'd31, 1, 32'd0);
    chk("R4 single bit unsigned", result_o, 32'd1);
    run_op(0, 1, 32'hf000_0000, 32'h0000_0001, 32'd28, 5, 32'd0);
    chk("R2 span", result_o, 32'hffff_ffff);

    // R5 R6 memory mode, random incl. negative positions
    for (int k = 0; k < 300; k++)
      run_op(1, k[0], $urandom, $urandom, $urandom, $urandom_range(32, 0), $urandom);
    run_op(1, 0, 32'h0, 32'h0, 32'hffff_fff8, 8, 32'h1000);
    chk("R5 negative offset", byte_addr_o, 32'h0fff);
    run_op(1, 0, 32'h0, 32'h0, 32'd7, 32, 32'h0);
    chk("R6 five bytes", 32'(byte_cnt_o), 32'd5);
    run_op(1, 0, 32'h0, 32'h0, 32'd0, 8, 32'h0);
    chk("R6 one byte", 32'(byte_cnt_o), 32'd1);
    hold_check();

    // R7 reserved operands
    run_op(0, 1, 32'hffff_ffff, 32'hffff_ffff, 32'd3, 33, 32'h55);
    run_op(1, 1, 32'hffff_ffff, 32'hffff_ffff, 32'd3, 63, 32'h55);
    run_op(0, 1, 32'hffff_ffff, 32'hffff_ffff, 32'd32, 4, 32'h0);
    run_op(0, 0, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 4, 32'h0);
    chk("R7 reserved result", result_o, 32'd0);
    run_op(1, 0, 32'hffff_ffff, 32'h0, 32'hffff_ffff, 4, 32'h0);
    chk("R7 memory pos allowed", 32'(rsvd_o), 32'd0);
    hold_check();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule